// File: doc/BRIEF.md
# Phase Comparator with Qualified Lock Indicator

This block sits between the two dividers of a frequency synthesizer and its analog charge pump. It watches the divided reference and the divided oscillator, both sampled by the crystal clock, and acts on their falling edges only. When the oscillator edge arrives first it raises an UP request; when the reference edge arrives first it raises a DOWN request. Either request is held until the other signal's edge arrives, so the request width in crystal clocks equals the phase error. Edges that land in the same clock cancel and give no request. A high-impedance enable tells the pump when to float.

A lock indicator is kept next to the comparator. Each reference period is timed by counting the crystal clocks in which a request is active. A period whose count reaches the width limit (one crystal clock by default) is bad. A bad pulse drops the indicator at once. The indicator rises only after a run of consecutive good periods (eight by default). Three control levels are also passed to the analog side: a pump-float test bit, a tuning-amplifier disable bit and a pump-current select bit.

Top module: `phase_lock_detect`

## Requirements
- R1: While rst_ni is low, and after it is released, up_o, dn_o and lock_o are 0 and pump_hiz_o is 1.
- R2: A falling edge on an input means it was 1 at one rising clock edge and 0 at the next. If div_i falls k clocks before ref_i falls (k ≥ 1), up_o is 1 for exactly k consecutive clocks, starting at the clock edge that samples the div_i fall, and dn_o stays 0.
- R3: If ref_i falls k clocks before div_i falls (k ≥ 1), dn_o is 1 for exactly k consecutive clocks, starting at the clock edge that samples the ref_i fall, and up_o stays 0.
- R4: Falling edges of both inputs sampled at the same clock edge produce no request, and pump_hiz_o stays 1.
- R5: pump_hiz_o is 0 only while a request is active and pump_off_i is 0. With pump_off_i at 1, pump_hiz_o is 1 and up_o and dn_o pulse unchanged.
- R6: On the clock edge after the active-request count within a reference period reaches WIDTH_LIMIT (default 1 clock), lock_o is 0.
- R7: A reference period is the span that ends in the clock sampling a ref_i falling edge. The first one starts at reset. lock_o goes to 1 at the clock edge that ends the GOOD_PERIODS-th consecutive good period (default 8).
- R8: A bad period restarts the good-period run. A DOWN pulse that starts at a reference edge counts against the period that edge begins.
- R9: cur_hi_o equals hi_cur_i: 1 selects the high pump current (220 µA), 0 the low one (50 µA).
- R10: tune_en_o is the inverse of tune_off_i: the tuning output is disabled when tune_off_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Divided reference, synchronous to clk_i |
| div_i | input | 1 | Divided oscillator, synchronous to clk_i |
| pump_off_i | input | 1 | Test bit: forces the pump to high impedance |
| tune_off_i | input | 1 | Tuning-amplifier disable bit |
| hi_cur_i | input | 1 | Pump-current select bit |
| up_o | output | 1 | Pump source request |
| dn_o | output | 1 | Pump sink request |
| pump_hiz_o | output | 1 | Pump high-impedance enable |
| cur_hi_o | output | 1 | Pump-current select level |
| tune_en_o | output | 1 | Tuning-output enable level |
| lock_o | output | 1 | Lock indicator |

## Verification
The comparator is driven with reference periods in which the oscillator edge leads, lags or coincides with the reference edge, at offsets of one to four clocks. The widths of up_o and dn_o and the count of low pump_hiz_o clocks are measured over each period, which tells the direction and size of the error apart from a simultaneous cancel. The same offsets are repeated with the float bit set, to show that it changes only the high-impedance enable. Lock sequences use seven and then eight clean periods, a short UP error, an error in the middle of a good run, and a one-clock DOWN error. The DOWN case shows that a pulse after the reference edge is charged to the next period and so needs one extra clean period.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef struct packed {
    logic up;
    logic dn;
  } pump_req_t;

  localparam int unsigned CMP_REF = 0;
  localparam int unsigned CMP_DIV = 1;
  localparam int unsigned CMP_N   = 2;
endpackage

// File: rtl/pd_fall_det.sv
module pd_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  assign fall_o = prev_q & ~sig_i;
endmodule

// File: rtl/pd_pfd.sv
module pd_pfd
  import pd_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      div_fall_i,
  input  logic      ref_fall_i,
  output pump_req_t req_o
);
  pump_req_t req_q, req_n;

  always_comb begin
    req_n.up = req_q.up | div_fall_i;
    req_n.dn = req_q.dn | ref_fall_i;
    if (req_n.up && req_n.dn) req_n = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_n;
  end

  assign req_o = req_q;

  // R2
  up_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_fall_i && !ref_fall_i && !req_q.dn |=> req_q.up);
  // R3
  dn_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_fall_i && !div_fall_i && !req_q.up |=> req_q.dn);
  // R4
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_fall_i && ref_fall_i && !req_q.up && !req_q.dn |=> !req_q.up && !req_q.dn);
  // R2 R3
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({req_q.up, req_q.dn}));
endmodule

// File: rtl/pd_lock_qual.sv
module pd_lock_qual #(
  parameter int unsigned WIDTH_LIMIT  = 1,
  parameter int unsigned GOOD_PERIODS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic ref_fall_i,
  output logic lock_o
);
  localparam int unsigned CW = (WIDTH_LIMIT  < 2) ? 1 : $clog2(WIDTH_LIMIT + 1);
  localparam int unsigned GW = (GOOD_PERIODS < 2) ? 1 : $clog2(GOOD_PERIODS + 1);
  localparam logic [CW:0]   LIM_W  = (CW+1)'(WIDTH_LIMIT);
  localparam logic [GW-1:0] GOOD_W = GW'(GOOD_PERIODS);

  logic [CW-1:0] wcnt_q, wcnt_n;
  logic [GW-1:0] good_q, good_n;
  logic          lock_q;
  logic [CW:0]   wsum;
  logic          too_long;

  // active clocks in this period, including the current one
  assign wsum     = {1'b0, wcnt_q} + (CW+1)'(act_i);
  assign too_long = (wsum >= LIM_W);

  always_comb begin
    wcnt_n = too_long ? LIM_W[CW-1:0] : wsum[CW-1:0];
    good_n = good_q;
    if (too_long) good_n = '0;
    if (ref_fall_i) begin
      wcnt_n = '0;
      if (!too_long && good_q != GOOD_W) good_n = good_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wcnt_q <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_n;
      good_q <= good_n;
      lock_q <= (good_n == GOOD_W);
    end
  end

  assign lock_o = lock_q;

  // R6
  wide_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    too_long |=> !lock_q);
  // R7
  lock_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_q) |-> $past(ref_fall_i) && !$past(too_long));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_fall_i && !lock_q |=> !lock_q);
endmodule

// File: rtl/phase_lock_detect.sv
module phase_lock_detect
  import pd_pkg::*;
#(
  parameter int unsigned WIDTH_LIMIT  = 1,
  parameter int unsigned GOOD_PERIODS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  input  logic div_i,
  input  logic pump_off_i,
  input  logic tune_off_i,
  input  logic hi_cur_i,
  output logic up_o,
  output logic dn_o,
  output logic pump_hiz_o,
  output logic cur_hi_o,
  output logic tune_en_o,
  output logic lock_o
);
  logic [CMP_N-1:0] cmp_in, cmp_fall;
  pump_req_t        req;

  assign cmp_in[CMP_REF] = ref_i;
  assign cmp_in[CMP_DIV] = div_i;

  for (genvar g = 0; g < CMP_N; g++) begin : g_edge
    pd_fall_det u_fd (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (cmp_in[g]),
      .fall_o (cmp_fall[g])
    );
  end

  pd_pfd u_pfd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .div_fall_i (cmp_fall[CMP_DIV]),
    .ref_fall_i (cmp_fall[CMP_REF]),
    .req_o      (req)
  );

  pd_lock_qual #(
    .WIDTH_LIMIT  (WIDTH_LIMIT),
    .GOOD_PERIODS (GOOD_PERIODS)
  ) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (req.up | req.dn),
    .ref_fall_i (cmp_fall[CMP_REF]),
    .lock_o     (lock_o)
  );

  assign up_o       = req.up;
  assign dn_o       = req.dn;
  assign pump_hiz_o = pump_off_i | ~(req.up | req.dn);
  assign cur_hi_o   = hi_cur_i;
  assign tune_en_o  = ~tune_off_i;

  // R5
  float_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !up_o && !dn_o |-> pump_hiz_o);
endmodule

// File: tb/sim_phase_lock_detect.sv
module sim_phase_lock_detect;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_i = 1'b0, div_i = 1'b0, pump_off_i = 1'b0, tune_off_i = 1'b0, hi_cur_i = 1'b0;
  logic up_o, dn_o, pump_hiz_o, cur_hi_o, tune_en_o, lock_o;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  phase_lock_detect u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ref_i(ref_i), .div_i(div_i),
    .pump_off_i(pump_off_i), .tune_off_i(tune_off_i), .hi_cur_i(hi_cur_i),
    .up_o(up_o), .dn_o(dn_o), .pump_hiz_o(pump_hiz_o), .cur_hi_o(cur_hi_o),
    .tune_en_o(tune_en_o), .lock_o(lock_o)
  );

  localparam int NV = 9;
  // offset (+ div leads, - ref leads), float bit, expected up, dn, hiz-low clocks
  localparam int V_OFF [NV] = '{ 0, 1, 3, -2, 4, -4, 2, -3, 0};
  localparam int V_T0  [NV] = '{ 0, 0, 0,  0, 0,  0, 1,  1, 1};
  localparam int V_UP  [NV] = '{ 0, 1, 3,  0, 4,  0, 2,  0, 0};
  localparam int V_DN  [NV] = '{ 0, 0, 0,  2, 0,  4, 0,  3, 0};
  localparam int V_HZL [NV] = '{ 0, 1, 3,  2, 4,  4, 0,  0, 0};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one 16-clock reference period; ref falls entering clock 8
  task automatic run_period(input int off, input logic t0,
                            output int nu, output int nd, output int nhl);
    nu = 0; nd = 0; nhl = 0;
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      nu  += int'(up_o);
      nd  += int'(dn_o);
      nhl += int'(!pump_hiz_o);
      ref_i      = (c < 8);
      div_i      = (c < 8 - off);
      pump_off_i = t0;
    end
  endtask

  task automatic goods(input int n);
    int a, b, h;
    for (int i = 0; i < n; i++) run_period(0, 1'b0, a, b, h);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_ni = 1'b0; ref_i = 1'b0; div_i = 1'b0; pump_off_i = 1'b0;
    #1;
    chk("R1 up in reset", int'(up_o), 0);
    chk("R1 lock in reset", int'(lock_o), 0);
    chk("R1 hiz in reset", int'(pump_hiz_o), 1);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int nu, nd, nhl;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 dn in reset", int'(dn_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 up after release", int'(up_o), 0);
    chk("R1 hiz after release", int'(pump_hiz_o), 1);

    // R2 R3 R4 R5 vector walk
    for (int v = 0; v < NV; v++) begin
      run_period(V_OFF[v], V_T0[v] != 0, nu, nd, nhl);
      chk(V_OFF[v] > 0 ? "R2 up width" : (V_OFF[v] == 0 ? "R4 up cancel" : "R3 up idle"), nu, V_UP[v]);
      chk(V_OFF[v] < 0 ? "R3 dn width" : (V_OFF[v] == 0 ? "R4 dn cancel" : "R2 dn idle"), nd, V_DN[v]);
      chk("R5 hiz low clocks", nhl, V_HZL[v]);
    end

    // R9 R10 level pass-through
    @(negedge clk);
    hi_cur_i = 1'b1; tune_off_i = 1'b0; #1;
    chk("R9 cur high", int'(cur_hi_o), 1);
    chk("R10 tune enabled", int'(tune_en_o), 1);
    @(negedge clk);
    hi_cur_i = 1'b0; tune_off_i = 1'b1; #1;
    chk("R9 cur low", int'(cur_hi_o), 0);
    chk("R10 tune disabled", int'(tune_en_o), 0);

    // R7 lock after eight good periods
    do_reset();
    goods(7);
    chk("R7 lock after 7 good", int'(lock_o), 0);
    goods(1);
    chk("R7 lock after 8 good", int'(lock_o), 1);

    // R6 single short UP error drops lock
    run_period(1, 1'b0, nu, nd, nhl);
    chk("R6 lock after up error", int'(lock_o), 0);
    goods(4);
    run_period(2, 1'b0, nu, nd, nhl);
    chk("R8 lock after mid-run error", int'(lock_o), 0);
    goods(7);
    chk("R8 lock after 7 more good", int'(lock_o), 0);
    goods(1);
    chk("R8 lock after 8 more good", int'(lock_o), 1);

    // R6 R8 one-clock DOWN error charged to next period
    run_period(-1, 1'b0, nu, nd, nhl);
    chk("R6 lock after dn error", int'(lock_o), 0);
    goods(8);
    chk("R8 lock after 8 good past dn", int'(lock_o), 0);
    goods(1);
    chk("R8 lock after 9 good past dn", int'(lock_o), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule